// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox

This block gives each of a small number of processor cores a 32-bit doorbell word. Any core may ring doorbells in any core's word by writing ones to that core's ring address. Only the bits written as one are set; bits written as zero keep their value. The owning core acknowledges doorbells by writing ones to its own acknowledge address, and it reads the same acknowledge address to see which doorbells are pending. A broadcast is a series of ring writes, one for each destination core.

Each core has a one-bit doorbell enable held in a per-core control word. A core's interrupt line is high while its doorbell word is non-zero and its enable bit is set. Register access uses a simple 32-bit bus with a valid strobe and a write flag. A read returns its data in the same cycle. A write takes effect at the next clock edge.

Top module: `ipi_mbox`

## Requirements
- R1: Reset (synchronous, active high) clears every doorbell word and every enable bit, so every interrupt line is low.
- R2: A write to the ring address of core c (byte offset 0x00 + 16*c) ORs the write data into core c's doorbell word. The other cores' words do not change.
- R3: A write to the acknowledge address of core c (byte offset 0x40 + 16*c) clears in core c's word each bit that is one in the write data. All other bits are kept.
- R4: A read of the acknowledge address of core c returns core c's doorbell word in the same cycle.
- R5: The enable word of core c is at byte offset 0x80 + 4*c. Only bit 0 is stored. A read returns that bit in bit 0 and zeros in bits 31:1.
- R6: irq_o[c] is high exactly when core c's doorbell word is non-zero and its enable bit is 1. It follows register state one cycle after the write.
- R7: If a ring and an acknowledge hit the same bit of the same word in the same cycle, the bit ends up set.
- R8: A read of a ring address or of an unmapped address returns zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid_i | input | 1 | Access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| ring_valid_i | input | 1 | Second ring port strobe, for a ring that arrives in the same cycle as a bus access |
| ring_core_i | input | 2 | Destination core of the second ring port |
| ring_bits_i | input | 32 | Bits set by the second ring port |
| irq_o | output | 4 | Per-core interrupt lines |

## Verification
The hardest case to reach is a ring and an acknowledge that hit the same bit in the same cycle. A single bus cannot carry both, so the second ring port is driven in the same cycle as a bus acknowledge write to the same core, and the word is then read back. The bench also sweeps ring and acknowledge writes for every core, using walking-one and mixed patterns. It checks every word after each write to confirm that no other core's word changed.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
    localparam int NCORES    = 4;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int CORE_W    = $clog2(NCORES);
    localparam logic [ADDR_W-1:0] RING_BASE = 8'h00;
    localparam logic [ADDR_W-1:0] ACK_BASE  = 8'h40;
    localparam logic [ADDR_W-1:0] EN_BASE   = 8'h80;

    typedef enum logic [1:0] {REG_NONE, REG_RING, REG_ACK, REG_EN} reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [CORE_W-1:0] core;
    } reg_sel_t;

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.kind = REG_NONE;
        s.core = '0;
        for (int c = 0; c < NCORES; c++) begin
            if (a == RING_BASE + ADDR_W'(16*c)) begin s.kind = REG_RING; s.core = CORE_W'(c); end
            if (a == ACK_BASE  + ADDR_W'(16*c)) begin s.kind = REG_ACK;  s.core = CORE_W'(c); end
            if (a == EN_BASE   + ADDR_W'(4*c))  begin s.kind = REG_EN;   s.core = CORE_W'(c); end
        end
        return s;
    endfunction
endpackage

// File: rtl/ipi_mbox_slot.sv
module ipi_mbox_slot
    import ipi_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] set_bits_i,
    input  logic [WORD_W-1:0] clr_bits_i,
    input  logic              en_we_i,
    input  logic              en_d_i,
    output logic [WORD_W-1:0] word_o,
    output logic              en_o,
    output logic              irq_o
);
    logic [WORD_W-1:0] word_q;
    logic              en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            en_q   <= 1'b0;
        end else begin
            word_q <= (word_q & ~clr_bits_i) | set_bits_i;
            if (en_we_i) en_q <= en_d_i;
        end
    end

    assign word_o = word_q;
    assign en_o   = en_q;
    assign irq_o  = en_q & (|word_q);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (set_bits_i != '0) |=> ((word_q & $past(set_bits_i)) == $past(set_bits_i)));
    assert_clear_only_R3: assert property (@(posedge clk) disable iff (rst)
        (set_bits_i == '0) |=> ((word_q & $past(clr_bits_i)) == '0));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (set_bits_i == '0 && clr_bits_i == '0) |=> $stable(word_q));
endmodule

// File: rtl/ipi_mbox_decode.sv
module ipi_mbox_decode
    import ipi_mbox_pkg::*;
(
    input  logic                  bus_valid_i,
    input  logic                  bus_write_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [WORD_W-1:0]     bus_wdata_i,
    input  logic                  ring_valid_i,
    input  logic [CORE_W-1:0]     ring_core_i,
    input  logic [WORD_W-1:0]     ring_bits_i,
    output logic [NCORES-1:0][WORD_W-1:0] set_o,
    output logic [NCORES-1:0][WORD_W-1:0] clr_o,
    output logic [NCORES-1:0]     en_we_o,
    output reg_sel_t              sel_o
);
    always_comb begin
        sel_o = decode(bus_addr_i);
        for (int c = 0; c < NCORES; c++) begin
            set_o[c]   = '0;
            clr_o[c]   = '0;
            en_we_o[c] = 1'b0;
            if (bus_valid_i && bus_write_i && sel_o.core == CORE_W'(c)) begin
                if (sel_o.kind == REG_RING) set_o[c] = bus_wdata_i;
                if (sel_o.kind == REG_ACK)  clr_o[c] = bus_wdata_i;
                if (sel_o.kind == REG_EN)   en_we_o[c] = 1'b1;
            end
            if (ring_valid_i && ring_core_i == CORE_W'(c))
                set_o[c] = set_o[c] | ring_bits_i;
        end
    end
endmodule

// File: rtl/ipi_mbox.sv
module ipi_mbox
    import ipi_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [7:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic              ring_valid_i,
    input  logic [1:0]        ring_core_i,
    input  logic [31:0]       ring_bits_i,
    output logic [3:0]        irq_o
);
    logic [NCORES-1:0][WORD_W-1:0] set_w, clr_w, words;
    logic [NCORES-1:0]             en_we, en_q;
    reg_sel_t                      sel;

    ipi_mbox_decode u_dec (
        .bus_valid_i, .bus_write_i, .bus_addr_i, .bus_wdata_i,
        .ring_valid_i, .ring_core_i, .ring_bits_i,
        .set_o(set_w), .clr_o(clr_w), .en_we_o(en_we), .sel_o(sel)
    );

    for (genvar c = 0; c < NCORES; c++) begin : g_slot
        ipi_mbox_slot u_slot (
            .clk, .rst,
            .set_bits_i(set_w[c]), .clr_bits_i(clr_w[c]),
            .en_we_i(en_we[c]), .en_d_i(bus_wdata_i[0]),
            .word_o(words[c]), .en_o(en_q[c]), .irq_o(irq_o[c])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_valid_i && !bus_write_i) begin
            case (sel.kind)
                REG_ACK: bus_rdata_o = words[sel.core];
                REG_EN:  bus_rdata_o = {31'b0, en_q[sel.core]};
                default: bus_rdata_o = '0;
            endcase
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (irq_o == '0));
    assert_irq_follow_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_o == '0) || (en_q != '0));
    assert_idle_read_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_i && !bus_write_i && !ring_valid_i) |=> $stable(words));
endmodule

// File: tb/ipi_mbox_tb_top.sv
module ipi_mbox_tb_top;
    logic clk = 0, rst = 1;
    logic bv = 0, bw = 0, rv = 0;
    logic [7:0] ba = 0;
    logic [31:0] bwd = 0, rb = 0, rd;
    logic [1:0] rc = 0;
    logic [3:0] irq;
    int checks = 0, errors = 0;
    logic [31:0] model [4];
    logic [3:0]  en_m;

    always #4 clk = ~clk;

    ipi_mbox dut_i (.clk, .rst, .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba),
        .bus_wdata_i(bwd), .bus_rdata_o(rd), .ring_valid_i(rv), .ring_core_i(rc),
        .ring_bits_i(rb), .irq_o(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bv = 1; bw = 1; ba = a; bwd = d;
        @(negedge clk); bv = 0; bw = 0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk); bv = 1; bw = 0; ba = a; #1;
        chk(req, rd, exp);
        bv = 0;
    endtask

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int c = 0; c < 4; c++) r[c] = en_m[c] & (|model[c]);
        return r;
    endfunction

    task automatic check_all(input string req);
        for (int c = 0; c < 4; c++) rdchk(req, 8'h40 + 8'(16*c), model[c]);
        chk("R6", {28'b0, irq}, {28'b0, exp_irq()});
    endtask

    initial begin
        for (int c = 0; c < 4; c++) model[c] = 0;
        en_m = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check_all("R1");
        for (int c = 0; c < 4; c++) rdchk("R1", 8'h80 + 8'(4*c), 0);
        // R2/R4: walking-one rings for every core
        for (int c = 0; c < 4; c++)
            for (int b = 0; b < 32; b += 5) begin
                wr(8'h00 + 8'(16*c), 32'h1 << b);
                model[c] |= 32'h1 << b;
                check_all("R2");
            end
        // R6: irq needs enable
        chk("R6", {28'b0, irq}, 0);
        for (int c = 0; c < 4; c += 2) begin
            wr(8'h80 + 8'(4*c), 32'hFFFF_FFFF);
            en_m[c] = 1;
            rdchk("R5", 8'h80 + 8'(4*c), 1);
        end
        check_all("R6");
        // R3: acknowledge patterns
        for (int c = 0; c < 4; c++) begin
            wr(8'h40 + 8'(16*c), 32'h0000_0421);
            model[c] &= ~32'h0000_0421;
            check_all("R3");
            wr(8'h00 + 8'(16*c), 32'hA5A5_0F0F);
            model[c] |= 32'hA5A5_0F0F;
            check_all("R2");
            wr(8'h40 + 8'(16*c), 32'hFFFF_FFFF);
            model[c] = 0;
            check_all("R3");
        end
        // R7: simultaneous ring and ack to same bits
        @(negedge clk); bv = 1; bw = 1; ba = 8'h50; bwd = 32'h0000_00FF;
        rv = 1; rc = 2'd1; rb = 32'h0000_0033;
        @(negedge clk); bv = 0; bw = 0; rv = 0;
        model[1] = 32'h0000_0033;
        check_all("R7");
        // R5: disable via bit 0 low
        wr(8'h80, 32'hFFFF_FFFE); en_m[0] = 0;
        rdchk("R5", 8'h80, 0);
        wr(8'h84, 32'h1); en_m[1] = 1;
        check_all("R6");
        // R8: ring address and unmapped reads return zero
        rdchk("R8", 8'h10, 0);
        rdchk("R8", 8'hC4, 0);
        rdchk("R8", 8'h44, 0);
        check_all("R8");
        // R1: reset again
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        for (int c = 0; c < 4; c++) model[c] = 0;
        en_m = 0;
        check_all("R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule